// File: doc/BRIEF.md
# Reversible Prescaled Up/Down Counter

This block is a long binary counter that steps by one on every clock edge, upward or downward as the `up` input selects. It is cut into sub-blocks of increasing width. The least significant sub-block is a single bit that toggles on every edge. Each wider sub-block moves only when every sub-block below it sits at its terminal value for the current direction.

A wider sub-block never has to do arithmetic on the edge where the direction turns around. Each one keeps a spare copy of its neighbouring value and a flag that says which way it is currently set to move. Suppose an event arrives that goes against that flag: a borrow while the block is set for upward steps, or a carry while it is set for downward steps. The block then swaps its digit with the spare copy and flips the flag.

Increments and decrements take an operand that was prepared in the cycle before. Terminal-value flags are also registered one cycle ahead. As a result, the carry decision on any edge is a short AND over a few flags and does not grow with the counter width. The counter width and the clock budget, counted in gate delays, set the partition. That partition is computed during elaboration.

Top module: `udc_shadow_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes zero. The first edge after release steps from zero.
- R2: On every edge with `up` high, `count` becomes its previous value plus one, modulo 2^CNT_W.
- R3: On every edge with `up` low, `count` becomes its previous value minus one, modulo 2^CNT_W.
- R4: `up` may change on any cycle, including every cycle. Each edge steps in the direction present at that edge.
- R5: When `count` is all ones and `up` is high, the next value is zero.
- R6: When `count` is zero and `up` is low, the next value is all ones.
- R7: Bit 0 of `count` inverts on every edge outside reset, in either direction.
- R8: Two steps in opposite directions return `count` exactly to the value it had before them. This holds when the first step crosses a sub-block boundary.
- R9: With the defaults (CNT_W = 16, CLK_P = 2) the sub-blocks, from the least significant end, are 1, 2 and 13 bits wide, at bit offsets 0, 1 and 3. Steps across the boundaries at bit 1 and bit 3 are correct in both directions.
- R10: Over long sequences of random directions, `count` always equals that of a plain reference up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up | input | 1 | Step direction: 1 counts upward, 0 counts downward |
| count | output | CNT_W | Current count, taken straight from the sub-block registers |

## Verification
The first patterns are long runs in one direction. They show plain increment and decrement, and the two wraps at zero and all ones. Alternating directions every cycle drive the swap path on every edge without any arithmetic in between. Up/down pairs placed at the 1→2, 3→4 and 7→8 boundaries show whether a swap restores exactly the neighbouring value, where an upper sub-block's state matters. A long random mix of run lengths and reversals, compared against a reference counter, catches stale precomputed operands and mistimed terminal flags.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // floor(log2(x)), zero for x <= 1
  function automatic int ilog2(input int x);
    int r;
    int v;
    r = 0;
    v = x;
    while (v > 1) begin
      v = v >> 1;
      r++;
    end
    return r;
  endfunction

  // Size of the lower part split off from an n-bit span for a clock
  // budget of p unit delays; never less than one bit.
  function automatic int low_part(input int n, input int p);
    int r;
    r = ilog2(n / p);
    if (r < 1) r = 1;
    return r;
  endfunction

  // Number of sub-blocks produced by the top-down split.
  function automatic int part_count(input int n, input int p);
    int rem;
    int c;
    rem = n;
    c = 1;
    while (rem > 1) begin
      rem = low_part(rem, p);
      c++;
    end
    return c;
  endfunction

  // Span remaining at the level that owns sub-block idx (0 = LSB).
  function automatic int blk_span(input int n, input int p, input int idx);
    int rem;
    int k;
    rem = n;
    k = part_count(n, p);
    for (int j = 0; j < k - 1 - idx; j++) rem = low_part(rem, p);
    return rem;
  endfunction

  function automatic int blk_w(input int n, input int p, input int idx);
    int rem;
    rem = blk_span(n, p, idx);
    return (rem > 1) ? rem - low_part(rem, p) : 1;
  endfunction

  function automatic int blk_off(input int n, input int p, input int idx);
    return blk_span(n, p, idx) - blk_w(n, p, idx);
  endfunction

endpackage

// File: rtl/cnt_lsb_bit.sv
module cnt_lsb_bit (
  input  logic clk,
  input  logic rst,
  output logic bit_o
);

  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= ~bit_q;
  end

  assign bit_o = bit_q;

  // R7: the lowest bit changes on every edge out of reset
  p_lsb_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bit_q != $past(bit_q)));

endmodule

// File: rtl/cnt_carry_net.sv
module cnt_carry_net #(
  parameter int NB = 3
) (
  input  logic          up_i,
  input  logic [NB-1:0] term_up_i,   // sub-block k at all ones
  input  logic [NB-1:0] term_dn_i,   // sub-block k at zero
  output logic [NB:1]   carry_o,     // carry into sub-block k (NB = whole-counter wrap)
  output logic [NB:1]   borrow_o
);

  logic [NB:1] run_up;
  logic [NB:1] run_dn;

  for (genvar k = 1; k <= NB; k++) begin : g_run
    if (k == 1) begin : g_first
      assign run_up[k] = term_up_i[0];
      assign run_dn[k] = term_dn_i[0];
    end else begin : g_next
      assign run_up[k] = run_up[k-1] & term_up_i[k-1];
      assign run_dn[k] = run_dn[k-1] & term_dn_i[k-1];
    end
    assign carry_o[k]  =  up_i & run_up[k];
    assign borrow_o[k] = ~up_i & run_dn[k];
  end

endmodule

// File: rtl/cnt_shadow_blk.sv
module cnt_shadow_blk #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         carry_i,
  input  logic         borrow_i,
  output logic [W-1:0] val_o,
  output logic         at_max_o,
  output logic         at_min_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] val_q, shd_q, ahead_q;
  logic         cfg_up_q;
  logic         at_max_q, at_min_q;

  logic         step_ev, swap_ev;
  logic [W-1:0] val_d;

  // matching event: arithmetic step; mismatching event: exchange
  assign step_ev = (carry_i & cfg_up_q) | (borrow_i & ~cfg_up_q);
  assign swap_ev = (carry_i & ~cfg_up_q) | (borrow_i & cfg_up_q);

  always_comb begin
    val_d = val_q;
    if (step_ev)      val_d = ahead_q;
    else if (swap_ev) val_d = shd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q    <= '0;
      shd_q    <= ONES;
      ahead_q  <= ONE;
      cfg_up_q <= 1'b1;
      at_max_q <= 1'b0;
      at_min_q <= 1'b1;
    end else begin
      val_q <= val_d;
      if (step_ev | swap_ev) shd_q <= val_q;
      if (swap_ev) cfg_up_q <= ~cfg_up_q;
      // operand for the next matching event, prepared one cycle early
      ahead_q  <= cfg_up_q ? val_q + ONE : val_q - ONE;
      at_max_q <= (val_d == ONES);
      at_min_q <= (val_d == '0);
    end
  end

  assign val_o    = val_q;
  assign at_max_o = at_max_q;
  assign at_min_o = at_min_q;

  // R8: shadow sits one below when set for upward steps
  p_shadow_below_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_up_q |-> (shd_q == val_q - ONE));

  // R8: shadow sits one above when set for downward steps
  p_shadow_above_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_up_q |-> (shd_q == val_q + ONE));

  // R4: a reversal restores the neighbouring value without arithmetic
  p_swap_restore_r4: assert property (@(posedge clk) disable iff (rst)
    swap_ev |=> (val_q == $past(shd_q)));

  // R2/R3: the prepared operand is current whenever a step uses it
  p_ahead_ready_r3: assert property (@(posedge clk) disable iff (rst)
    step_ev |-> (ahead_q == (cfg_up_q ? val_q + ONE : val_q - ONE)));

  // R4: a carry and a borrow never reach the same sub-block together
  p_single_event_r4: assert property (@(posedge clk) disable iff (rst)
    !(carry_i && borrow_i));

endmodule

// File: rtl/udc_shadow_counter.sv
module udc_shadow_counter #(
  parameter int CNT_W = 16,   // total width, at least 2
  parameter int CLK_P = 2     // clock budget in unit delays, at least 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  output logic [CNT_W-1:0] count
);

  localparam int NBLK = udc_pkg::part_count(CNT_W, CLK_P);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [NBLK-1:0] term_up, term_dn;
  logic [NBLK:1]   carry, borrow;
  logic            lsb;

  cnt_lsb_bit u_lsb (
    .clk   (clk),
    .rst   (rst),
    .bit_o (lsb)
  );

  assign term_up[0] = lsb;
  assign term_dn[0] = ~lsb;
  assign count[0]   = lsb;

  cnt_carry_net #(.NB(NBLK)) u_net (
    .up_i      (up),
    .term_up_i (term_up),
    .term_dn_i (term_dn),
    .carry_o   (carry),
    .borrow_o  (borrow)
  );

  for (genvar i = 1; i < NBLK; i++) begin : g_blk
    localparam int BW = udc_pkg::blk_w(CNT_W, CLK_P, i);
    localparam int BO = udc_pkg::blk_off(CNT_W, CLK_P, i);
    logic [BW-1:0] v;

    cnt_shadow_blk #(.W(BW)) u_blk (
      .clk      (clk),
      .rst      (rst),
      .carry_i  (carry[i]),
      .borrow_i (borrow[i]),
      .val_o    (v),
      .at_max_o (term_up[i]),
      .at_min_o (term_dn[i])
    );

    assign count[BO +: BW] = v;
  end

  // R2 and R3: every edge moves the count by one in the chosen direction
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == ($past(up) ? $past(count) + STEP : $past(count) - STEP)));

  // R5: a carry out of the top sub-block lands on zero
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    carry[NBLK] |=> (count == '0));

  // R6: a borrow out of the top sub-block lands on all ones
  p_wrap_dn_r6: assert property (@(posedge clk) disable iff (rst)
    borrow[NBLK] |=> (count == '1));

endmodule

// File: tb/udc_shadow_counter_bench.sv
`timescale 1ns/1ps
module udc_shadow_counter_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         up;
  logic [W-1:0] count;
  logic [W-1:0] exp_cnt;
  int           n_chk = 0;
  int           n_err = 0;

  always #5 clk = ~clk;

  udc_shadow_counter #(.CNT_W(W), .CLK_P(2)) u_udc_shadow_counter (
    .clk   (clk),
    .rst   (rst),
    .up    (up),
    .count (count)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] v, input logic d);
    return d ? v + W'(1) : v - W'(1);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: count=%h expected=%h", tag, act, expv);
    end
  endtask

  // one edge in direction d; compares the count and the bit-0 toggle (R7)
  task automatic step(input logic d, input string tag);
    logic prev0;
    prev0 = count[0];
    up = d;
    @(posedge clk);
    #1;
    exp_cnt = ref_next(exp_cnt, d);
    check(tag, count, exp_cnt);
    check("R7 bit0 toggle", {{(W-1){1'b0}}, count[0]}, {{(W-1){1'b0}}, ~prev0});
  endtask

  // R8: two opposite steps restore the starting value
  task automatic pair(input logic first, input string tag);
    logic [W-1:0] start;
    start = count;
    step(first, tag);
    step(~first, tag);
    check(tag, count, start);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: count=%h expected=%h", count, exp_cnt);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c47));
    rst = 1'b1;
    up  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", count, '0);
    rst = 1'b0;
    exp_cnt = '0;

    // R6 then R5: wrap downward from zero, wrap upward back
    step(1'b0, "R6 down from zero");
    check("R6 all ones", count, '1);
    step(1'b1, "R5 up from all ones");
    check("R5 zero", count, '0);

    // R9: climb across the bit-1 and bit-3 boundaries, reverse on them
    for (int i = 0; i < 8; i++) step(1'b1, "R9 climb");
    check("R9 reached 8", count, W'(8));
    step(1'b0, "R9 8 to 7");
    step(1'b1, "R9 7 to 8");
    for (int i = 0; i < 8; i++) step(1'b0, "R9 descend");
    check("R9 back to 0", count, '0);

    // R8: reversal pairs at boundary values
    for (int i = 0; i < 9; i++) begin
      pair(1'b1, "R8 up-down pair");
      pair(1'b0, "R8 down-up pair");
      step(1'b1, "R2 advance");
    end

    // R4: direction changes on every edge
    for (int i = 0; i < 40; i++) step(i[0], "R4 alternating");

    // R2 and R3: long one-way runs
    for (int i = 0; i < 300; i++) step(1'b1, "R2 up run");
    for (int i = 0; i < 700; i++) step(1'b0, "R3 down run");

    // R10: random run lengths and reversals against the reference
    for (int i = 0; i < 3000; i++) begin
      logic d;
      int   len;
      d   = $urandom_range(1, 0) != 0;
      len = ($urandom_range(3, 0) == 0) ? $urandom_range(40, 1) : $urandom_range(3, 1);
      for (int j = 0; j < len; j++) step(d, "R10 random");
    end

    // R1: reset mid-count returns to zero
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset mid-count", count, '0);
    rst = 1'b0;
    exp_cnt = '0;
    step(1'b1, "R1 first step after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule